// File: doc/BRIEF.md
# Multi-Cycle Context Sequencer

This block is a single processing element fed by a context sequencer. A program counter addresses an external context store with a combinational read port. On every cycle the returned 16-bit context word is captured in a context register, and the element executes it in the following cycle. The context register breaks the path from the store read to the element datapath. Single-cycle words update a 16-bit accumulator through a small ALU. The accumulator value is the element result.

A context word can mark itself as a long operation and carry its own duration. Such a word hands the accumulator datapath to a two-state FSM in the element, which runs a shift-and-add multiply for the encoded number of iterations. For that whole time the sequencer freezes the program counter and the context register, and `busy` stays high. In the last cycle `done` pulses, and on the same edge the program counter moves on and the next word is loaded. No issue slot is lost.

The FSM has two states. `S_EXEC` executes one word per cycle, and a long word moves it to `S_MULT`. `S_MULT` performs one multiply iteration per cycle and returns to `S_EXEC` when the final iteration is done. The sequencer holds whenever `busy` is high and `done` is low.

Top module: `ctx_seq_top`

## Requirements
- R1: Context word layout: bit 15 is the long flag, bits 14:11 the count, bits 10:8 the opcode and bits 7:0 the immediate. When not holding, each clock edge loads the store word at `store_addr` into the context register (`ctx_out`) and increments `store_addr` by one, wrapping modulo 2^ADDR_W.
- R2: Single-cycle opcodes act on the accumulator at the end of the cycle in which the word is in the context register. The immediate is zero-extended. The encodings are 0 none, 1 load, 2 add, 3 subtract, 4 and, 5 or, 6 xor, and 7 shift left by imm[3:0]. Arithmetic is modulo 2^DATA_W.
- R3: A word with bit 15 set and count N ≥ 2 stays in the context register for exactly N cycles, with `busy` high in each of them.
- R4: While a long word is running, `store_addr` and `ctx_out` do not change until the cycle of `done`.
- R5: A word with bit 15 set and count 0 or 1 executes its opcode as a single-cycle word, with no hold and `busy` low.
- R6: `done` is high only in the last cycle of a long word. The next store word appears in `ctx_out` in the following cycle.
- R7: A long word ignores its opcode. At the end of its last cycle it writes acc × (imm mod 2^min(N,8)) mod 2^DATA_W to `result`.
- R8: While `rst` is high, `store_addr`, `ctx_out` and `result` are zero, and `busy` and `done` are low.
- R9: While a long word runs, `result` keeps its value from before the word until the word completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| store_addr | output | ADDR_W (4) | Context store read address (program counter) |
| store_data | input | 16 | Context store read data, same cycle |
| ctx_out | output | 16 | Context register contents |
| busy | output | 1 | Long operation in progress |
| done | output | 1 | Last cycle of a long operation |
| result | output | DATA_W (16) | Element accumulator |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 16, so a program of sixteen words visits every store address and wraps back to address 0. It tests the boundary between short and long words, using counts of 0, 1, 2, 8 and 15. Counts above 8 run iterations that add nothing, which shows that they cost only cycles. The 16-bit accumulator lets multiplies overflow and wrap, and back-to-back long words test the issue of a new word on the same edge as `done`.

// File: rtl/ctxseq_pkg.sv
package ctxseq_pkg;

    localparam int WORD_W = 16;
    localparam int CNT_W  = 4;
    localparam int IMM_W  = 8;
    localparam int SHAMT_W = 4;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_LDI = 3'd1,
        OP_ADD = 3'd2,
        OP_SUB = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_SHL = 3'd7
    } op_e;

    // bit 15 long flag, 14:11 count, 10:8 opcode, 7:0 immediate
    typedef struct packed {
        logic             longop;
        logic [CNT_W-1:0] cnt;
        op_e              op;
        logic [IMM_W-1:0] imm;
    } ctx_word_t;

    typedef enum logic {
        S_EXEC = 1'b0,
        S_MULT = 1'b1
    } pe_state_e;

endpackage

// File: rtl/ctx_fetch.sv
module ctx_fetch
    import ctxseq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_i,
    input  ctx_word_t         store_word_i,
    output logic [ADDR_W-1:0] pc_o,
    output ctx_word_t         ctx_o
);

    logic [ADDR_W-1:0] pc_q;
    ctx_word_t         ctx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ctx_q <= '0;
        end else if (!hold_i) begin
            pc_q  <= pc_q + ADDR_W'(1);
            ctx_q <= store_word_i;
        end
    end

    assign pc_o  = pc_q;
    assign ctx_o = ctx_q;

    AST_ISSUE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !hold_i |=> (pc_q == $past(pc_q) + ADDR_W'(1))); // R1

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> (pc_q == $past(pc_q) && ctx_q == $past(ctx_q))); // R4

endmodule

// File: rtl/pe_alu.sv
module pe_alu
    import ctxseq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_e               op_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] acc_i,
    output logic [DATA_W-1:0] res_o
);

    logic [DATA_W-1:0] imm_ext;

    assign imm_ext = DATA_W'(imm_i);

    always_comb begin
        unique case (op_i)
            OP_NOP: res_o = acc_i;
            OP_LDI: res_o = imm_ext;
            OP_ADD: res_o = acc_i + imm_ext;
            OP_SUB: res_o = acc_i - imm_ext;
            OP_AND: res_o = acc_i & imm_ext;
            OP_OR:  res_o = acc_i | imm_ext;
            OP_XOR: res_o = acc_i ^ imm_ext;
            OP_SHL: res_o = acc_i << imm_i[SHAMT_W-1:0];
        endcase
    end

endmodule

// File: rtl/pe_ctrl.sv
module pe_ctrl
    import ctxseq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  ctx_word_t         ctx_i,
    input  logic [DATA_W-1:0] alu_res_i,
    output logic [DATA_W-1:0] acc_o,
    output logic              busy_o,
    output logic              done_o
);

    pe_state_e         state_q, state_d;
    logic [DATA_W-1:0] acc_q, acc_d;
    logic [DATA_W-1:0] prod_q, prod_d;
    logic [DATA_W-1:0] mcand_q, mcand_d;
    logic [IMM_W-1:0]  mplier_q, mplier_d;
    logic [CNT_W-1:0]  left_q, left_d;
    logic              long_word;

    assign long_word = ctx_i.longop && (ctx_i.cnt >= CNT_W'(2));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_EXEC;
            acc_q    <= '0;
            prod_q   <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            left_q   <= '0;
        end else begin
            state_q  <= state_d;
            acc_q    <= acc_d;
            prod_q   <= prod_d;
            mcand_q  <= mcand_d;
            mplier_q <= mplier_d;
            left_q   <= left_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        acc_d    = acc_q;
        prod_d   = prod_q;
        mcand_d  = mcand_q;
        mplier_d = mplier_q;
        left_d   = left_q;
        busy_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            S_EXEC: begin
                if (long_word) begin
                    busy_o   = 1'b1;
                    prod_d   = ctx_i.imm[0] ? acc_q : '0;
                    mcand_d  = acc_q << 1;
                    mplier_d = ctx_i.imm >> 1;
                    left_d   = ctx_i.cnt - CNT_W'(1);
                    state_d  = S_MULT;
                end else begin
                    acc_d = alu_res_i;
                end
            end
            S_MULT: begin
                busy_o   = 1'b1;
                prod_d   = prod_q + (mplier_q[0] ? mcand_q : '0);
                mcand_d  = mcand_q << 1;
                mplier_d = mplier_q >> 1;
                left_d   = left_q - CNT_W'(1);
                if (left_q == CNT_W'(1)) begin
                    done_o  = 1'b1;
                    acc_d   = prod_d;
                    state_d = S_EXEC;
                end
            end
        endcase
    end

    assign acc_o = acc_q;

    // checker: length of each long run, counted apart from the FSM counter
    logic [CNT_W-1:0] chk_len_q, chk_elapsed_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_len_q     <= '0;
            chk_elapsed_q <= '0;
        end else if (state_q == S_EXEC && busy_o) begin
            chk_len_q     <= ctx_i.cnt;
            chk_elapsed_q <= CNT_W'(1);
        end else if (state_q == S_MULT) begin
            chk_elapsed_q <= chk_elapsed_q + CNT_W'(1);
        end
    end

    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (chk_elapsed_q == chk_len_q - CNT_W'(1))); // R3

    AST_SHORT_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_EXEC && ctx_i.longop && ctx_i.cnt < CNT_W'(2)) |=> (state_q == S_EXEC)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R6

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o); // R6

    AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> (acc_q == $past(acc_q))); // R9

endmodule

// File: rtl/ctx_seq_top.sv
module ctx_seq_top
    import ctxseq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] store_addr,
    input  logic [15:0]       store_data,
    output logic [15:0]       ctx_out,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);

    ctx_word_t         ctx_w;
    logic [DATA_W-1:0] acc_w, alu_w;
    logic              hold_w;

    assign hold_w = busy && !done;

    ctx_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk          (clk),
        .rst          (rst),
        .hold_i       (hold_w),
        .store_word_i (ctx_word_t'(store_data)),
        .pc_o         (store_addr),
        .ctx_o        (ctx_w)
    );

    pe_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i  (ctx_w.op),
        .imm_i (ctx_w.imm),
        .acc_i (acc_w),
        .res_o (alu_w)
    );

    pe_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctx_i     (ctx_w),
        .alu_res_i (alu_w),
        .acc_o     (acc_w),
        .busy_o    (busy),
        .done_o    (done)
    );

    assign ctx_out = 16'(ctx_w);
    assign result  = acc_w;

endmodule

// File: tb/tb_ctx_seq_top.sv
module tb_ctx_seq_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  store_addr;
    logic [15:0] store_data;
    logic [15:0] ctx_out;
    logic        busy, done;
    logic [15:0] result;

    logic [15:0] mem [16];

    int n_checks = 0;
    int n_bad = 0;

    typedef struct {
        logic [15:0] word;
        logic [15:0] acc;
        int          dur;
        logic [3:0]  addr;
    } item_t;

    item_t sbq[$];
    logic  pending = 1'b0;

    always #10 clk = ~clk;

    assign store_data = mem[store_addr];

    ctx_seq_top #(.ADDR_W(4), .DATA_W(16)) dut (
        .clk(clk), .rst(rst), .store_addr(store_addr), .store_data(store_data),
        .ctx_out(ctx_out), .busy(busy), .done(done), .result(result)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [15:0] acc, input logic [15:0] w);
        logic [3:0] cnt;
        logic [7:0] imm;
        int         n;
        logic [7:0] m;
        cnt = w[14:11];
        imm = w[7:0];
        if (w[15] && cnt >= 2) begin
            n = (cnt > 8) ? 8 : int'(cnt);
            m = imm & 8'((1 << n) - 1);
            return 16'(acc * {8'h00, m});
        end
        case (w[10:8])
            3'd0: return acc;
            3'd1: return {8'h00, imm};
            3'd2: return acc + {8'h00, imm};
            3'd3: return acc - {8'h00, imm};
            3'd4: return acc & {8'h00, imm};
            3'd5: return acc | {8'h00, imm};
            3'd6: return acc ^ {8'h00, imm};
            default: return acc << imm[3:0];
        endcase
    endfunction

    function automatic logic [15:0] mk(input logic lf, input int cnt, input int op, input int imm);
        return {lf, 4'(cnt), 3'(op), 8'(imm)};
    endfunction

    // driver: reset, push expected items for one pass, release, wait for drain
    task automatic run_prog();
        logic [15:0] acc;
        item_t       it;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R8 addr", 32'(store_addr), 0);
        check("R8 ctx", 32'(ctx_out), 0);
        check("R8 result", 32'(result), 0);
        check("R8 busy/done", {busy, done}, 0);
        acc = '0;
        it.word = 16'h0; it.acc = 16'h0; it.dur = 1; it.addr = 4'd0;
        sbq.push_back(it);
        for (int i = 0; i < 16; i++) begin
            acc = model(acc, mem[i]);
            it.word = mem[i];
            it.acc  = acc;
            it.dur  = (mem[i][15] && mem[i][14:11] >= 2) ? int'(mem[i][14:11]) : 1;
            it.addr = 4'(i + 1);
            sbq.push_back(it);
        end
        @(posedge clk);
        #1 rst = 1'b0;
        while (sbq.size() != 0 || pending) @(posedge clk);
        #1 rst = 1'b1;
    endtask

    // monitor
    initial begin
        int          cyc;
        logic [15:0] last_acc;
        logic [15:0] pend_val;
        item_t       it;
        cyc = 0;
        last_acc = '0;
        pend_val = '0;
        forever begin
            @(negedge clk);
            if (rst) begin
                cyc = 0;
                pending = 1'b0;
                last_acc = '0;
            end else begin
                if (pending) begin
                    check("R2/R7 result", 32'(result), 32'(pend_val));
                    pending = 1'b0;
                end
                cyc++;
                if (sbq.size() != 0) begin
                    if (busy && !done) begin
                        check("R4 addr held", 32'(store_addr), 32'(sbq[0].addr));
                        check("R4 ctx held", 32'(ctx_out), 32'(sbq[0].word));
                        check("R9 result frozen", 32'(result), 32'(last_acc));
                        check("R3 busy in long", 32'(cyc < sbq[0].dur), 1);
                    end else begin
                        it = sbq.pop_front();
                        check("R1 ctx word", 32'(ctx_out), 32'(it.word));
                        check("R1 addr", 32'(store_addr), 32'(it.addr));
                        check(it.dur > 1 ? "R3 duration" : "R5 duration", 32'(cyc), 32'(it.dur));
                        check("R6 done", 32'(done), 32'(it.dur > 1));
                        check("R5/R3 busy", 32'(busy), 32'(it.dur > 1));
                        pend_val = it.acc;
                        last_acc = it.acc;
                        pending = 1'b1;
                        cyc = 0;
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        // program A: single-cycle ops, short long-flag words (R2, R5)
        mem[0]  = mk(0, 0, 1, 8'h5A);
        mem[1]  = mk(0, 0, 2, 8'h30);
        mem[2]  = mk(0, 0, 3, 8'hFF);
        mem[3]  = mk(0, 0, 4, 8'h0F);
        mem[4]  = mk(0, 0, 5, 8'hC0);
        mem[5]  = mk(0, 0, 6, 8'hFF);
        mem[6]  = mk(0, 0, 7, 4);
        mem[7]  = mk(0, 0, 0, 8'h77);
        mem[8]  = mk(1, 0, 2, 7);
        mem[9]  = mk(1, 1, 3, 2);
        mem[10] = mk(0, 0, 1, 8'hFF);
        mem[11] = mk(0, 0, 7, 15);
        mem[12] = mk(0, 0, 2, 1);
        mem[13] = mk(0, 0, 3, 1);
        mem[14] = mk(1, 1, 6, 8'h80);
        mem[15] = mk(0, 9, 5, 1);
        run_prog();
        // program B: long multiplies of various lengths (R3, R4, R6, R7, R9)
        mem[0]  = mk(0, 0, 1, 7);
        mem[1]  = mk(1, 4, 0, 8'h0B);
        mem[2]  = mk(1, 2, 1, 3);
        mem[3]  = mk(0, 0, 2, 1);
        mem[4]  = mk(1, 15, 6, 8'hFF);
        mem[5]  = mk(1, 8, 5, 8'h81);
        mem[6]  = mk(1, 3, 0, 8'hFF);
        mem[7]  = mk(0, 0, 1, 8'hAB);
        mem[8]  = mk(1, 2, 0, 0);
        mem[9]  = mk(0, 0, 1, 9);
        mem[10] = mk(1, 5, 2, 8'h1F);
        mem[11] = mk(1, 6, 0, 8'h02);
        mem[12] = mk(1, 1, 2, 5);
        mem[13] = mk(1, 0, 1, 8'hC3);
        mem[14] = mk(1, 7, 0, 8'h7F);
        mem[15] = mk(1, 2, 3, 3);
        run_prog();
        // program C: back-to-back long words through the address wrap (R1, R6)
        mem[0] = mk(0, 0, 1, 3);
        for (int i = 1; i < 16; i++) mem[i] = mk(1, 2 + (i % 3), i % 8, 8'h03 + i);
        run_prog();
        repeat (3) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule